// File: doc/BRIEF.md
# Cascaded-Accumulator Noise-Shaping Modulator

This block turns a wide unsigned fractional word into a short signed code. The code comes out once per enabled clock. Its long-run average tracks the fraction, and its quantisation error is pushed toward high frequencies. Typical loads are a fractional clock divider or a low-resolution converter that runs at the clock rate.

The block is a chain of up to three wrapping accumulators. The first one sums the input word. Each later one sums the residue that the previous stage holds after its update. There is no loop outside the individual accumulators, so the block is stable for every input value. The carry bits of the stages are merged by differencing terms and unit delays: stage one contributes its carry directly, stage two contributes a first difference, and stage three a second difference. The parameter `ORDER` (1 to 3) selects the number of stages, and the output range widens as the order rises.

Top module: `mash_dsm`

## Requirements
- R1: While `rst_n` is low, every accumulator and every carry delay register is cleared and `code_out` reads 0. After release, the block behaves as if it starts from all-zero state.
- R2: With `ORDER`=1, on each enabled edge the stage accumulator becomes (acc + `frac_in`) mod 2^`ACC_W`, and `code_out` takes the carry out of that addition, so it is 0 or 1.
- R3: `code_out`, read as two's complement, stays in [0,1] for order 1, in [-1,2] for order 2 and in [-3,4] for order 3. This needs `OUT_W` of at least 4.
- R4: While `en` is low, `code_out` and all internal state hold, whatever `frac_in` is. When `en` returns high, the sequence resumes as if the idle cycles had not occurred.
- R5: If `frac_in` has been 0 on every enabled edge since reset, `code_out` stays 0.
- R6: From reset, with a constant input x held for 2^`ACC_W` enabled edges, the sum of the outputs lies in [x-1, x+2] for order 3 and equals x exactly for order 1.
- R7: With `ORDER`=3, on each enabled edge stage 1 adds `frac_in`, stage 2 adds the new stage-1 residue, and stage 3 adds the new stage-2 residue, each one wrapping at 2^`ACC_W` with carries c1, c2 and c3. The registered output is c1 + c2 - c2' + c3 - 2*c3' + c3''. Here c2' and c3' are the carries of the previous enabled edge and c3'' is the carry of the edge before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the modulator by one step |
| frac_in | input | ACC_W | Unsigned fraction, value / 2^ACC_W |
| code_out | output | OUT_W | Signed output code, registered |

## Verification
The assertions take for granted that reset is applied at the start of a run, so that the all-zero history tracked by the checker is valid. They also assume that `OUT_W` is wide enough for the chosen order, so that the range check does not wrap. Stimulus holds reset low for the first clock edges. It changes `en` and `frac_in` only on falling edges, and it sweeps the whole input range: zero, one, the maximum, a midpoint and random values, with random idle gaps. The default output width covers order 3.

// File: rtl/mash_dsm.sv
module mash_dsm #(
  parameter int ACC_W = 16,
  parameter int ORDER = 3,
  parameter int OUT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ACC_W-1:0]        frac_in,
  output logic signed [OUT_W-1:0] code_out
);

  logic [ACC_W-1:0] acc [ORDER];
  logic [ACC_W-1:0] nxt [ORDER];
  logic [ORDER-1:0] cy;
  logic [OUT_W-1:0] sum;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign {cy[g], nxt[g]} = {1'b0, acc[g]} + {1'b0, frac_in};
    end else begin : g_tail
      assign {cy[g], nxt[g]} = {1'b0, acc[g]} + {1'b0, nxt[g-1]};
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  acc[g] <= '0;
      else if (en) acc[g] <= nxt[g];
  end

  if (ORDER == 1) begin : g_o1
    assign sum = OUT_W'(cy[0]);
  end else if (ORDER == 2) begin : g_o2
    logic c2_d1;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  c2_d1 <= 1'b0;
      else if (en) c2_d1 <= cy[1];
    assign sum = OUT_W'(cy[0]) + OUT_W'(cy[1]) - OUT_W'(c2_d1);
  end else begin : g_o3
    logic c2_d1, c3_d1, c3_d2;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        c2_d1 <= 1'b0;
        c3_d1 <= 1'b0;
        c3_d2 <= 1'b0;
      end else if (en) begin
        c2_d1 <= cy[1];
        c3_d1 <= cy[2];
        c3_d2 <= c3_d1;
      end
    assign sum = OUT_W'(cy[0]) + OUT_W'(cy[1]) - OUT_W'(c2_d1)
               + OUT_W'(cy[2]) - OUT_W'({c3_d1, 1'b0}) + OUT_W'(c3_d2);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  code_out <= '0;
    else if (en) code_out <= sum;

endmodule

// File: rtl/mash_dsm_chk.sv
module mash_dsm_chk #(
  parameter int ACC_W = 16,
  parameter int ORDER = 3,
  parameter int OUT_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [ACC_W-1:0]        frac_in,
  input logic signed [OUT_W-1:0] code_out
);

  localparam int LO = (ORDER == 1) ? 0 : (ORDER == 2) ? -1 : -3;
  localparam int HI = (ORDER == 1) ? 1 : (ORDER == 2) ? 2 : 4;

  logic all_zero;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) all_zero <= 1'b1;
    else if (en && frac_in != '0) all_zero <= 1'b0;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> code_out == '0);

  assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code_out) >= LO) && (int'(code_out) <= HI));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(code_out));

  assert_zero_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    all_zero |-> code_out == '0);

endmodule

bind mash_dsm mash_dsm_chk #(.ACC_W(ACC_W), .ORDER(ORDER), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .frac_in(frac_in), .code_out(code_out)
);

// File: tb/mash_dsm_bench.sv
`timescale 1ns/1ps
module mash_dsm_bench;
  localparam int W = 8;
  localparam int OW = 4;
  localparam int unsigned MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] frac = '0;
  logic signed [OW-1:0] out3, out1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mash_dsm #(.ACC_W(W), .ORDER(3), .OUT_W(OW)) u_mash_dsm (
    .clk(clk), .rst_n(rst_n), .en(en), .frac_in(frac), .code_out(out3));
  mash_dsm #(.ACC_W(W), .ORDER(1), .OUT_W(OW)) u_mash_dsm_ord1 (
    .clk(clk), .rst_n(rst_n), .en(en), .frac_in(frac), .code_out(out1));

  int unsigned macc [2][3];
  bit mc2d [2], mc3d1 [2], mc3d2 [2];
  int mout [2];
  int ords [2] = '{3, 1};

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 3; s++) macc[k][s] = 0;
      mc2d[k] = 0; mc3d1[k] = 0; mc3d2[k] = 0; mout[k] = 0;
    end
  endtask

  task automatic model_step(int k, int unsigned x);
    int unsigned in_v, s_v;
    bit c [3];
    int y;
    in_v = x;
    c = '{0, 0, 0};
    for (int s = 0; s < ords[k]; s++) begin
      s_v = macc[k][s] + in_v;
      c[s] = s_v[W];
      macc[k][s] = s_v & MASK;
      in_v = macc[k][s];
    end
    y = c[0];
    if (ords[k] >= 2) y += int'(c[1]) - int'(mc2d[k]);
    if (ords[k] == 3) y += int'(c[2]) - 2 * int'(mc3d1[k]) + int'(mc3d2[k]);
    mc2d[k] = c[1];
    mc3d2[k] = mc3d1[k];
    mc3d1[k] = c[2];
    mout[k] = y;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(bit r, bit e, int unsigned x, string tag3, string tag1);
    rst_n = r; en = e; frac = x[W-1:0];
    @(posedge clk);
    @(negedge clk);
    if (!r) model_reset();
    else if (e) begin
      model_step(0, x);
      model_step(1, x);
    end
    check(int'(out3) == mout[0], tag3, int'(out3), mout[0]);
    check(int'(out1) == mout[1], tag1, int'(out1), mout[1]);
    check(int'(out3) >= -3 && int'(out3) <= 4, "R3 range", int'(out3), 0);
  endtask

  initial begin
    int sum3, sum1;
    int prev3, prev1;
    void'($urandom(32'd20240607));
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick(0, 1, 8'hA5, "R1 reset ord3", "R1 reset ord1");
    for (int i = 0; i < 20; i++) tick(1, 1, 0, "R5 zero ord3", "R5 zero ord1");
    for (int i = 0; i < 12; i++) tick(1, 1, 1, "R7 x=1", "R2 x=1");
    for (int i = 0; i < 300; i++) tick(1, 1, MASK, "R7 x=max", "R2 x=max");
    for (int i = 0; i < 40; i++) tick(1, 1, 128, "R7 x=half", "R2 x=half");
    prev3 = int'(out3); prev1 = int'(out1);
    for (int i = 0; i < 10; i++) begin
      tick(1, 0, $urandom & MASK, "R4 idle ord3", "R4 idle ord1");
      check(int'(out3) == prev3, "R4 hold ord3", int'(out3), prev3);
      check(int'(out1) == prev1, "R4 hold ord1", int'(out1), prev1);
    end
    for (int i = 0; i < 20; i++) tick(1, 1, 93, "R4 resume ord3", "R4 resume ord1");
    for (int i = 0; i < 3000; i++)
      tick(1, ($urandom % 5) != 0, $urandom & MASK, "R7 random", "R2 random");
    tick(0, 1, 0, "R1 mid reset ord3", "R1 mid reset ord1");
    check(int'(out3) == 0, "R1 out3 zero", int'(out3), 0);
    for (int i = 0; i < 15; i++) tick(1, 1, 0, "R1 cleared ord3", "R1 cleared ord1");
    tick(0, 1, 0, "R1 reset ord3", "R1 reset ord1");
    sum3 = 0; sum1 = 0;
    for (int i = 0; i < (1 << W); i++) begin
      tick(1, 1, 77, "R7 mean run", "R2 mean run");
      sum3 += int'(out3); sum1 += int'(out1);
    end
    check(sum3 >= 76 && sum3 <= 79, "R6 mean ord3", sum3, 77);
    check(sum1 == 77, "R6 mean ord1", sum1, 77);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule